// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of a read or write burst inside a synchronous DRAM. A start strobe carries the starting column, a burst length code and an ordering choice. From the next cycle on, the block puts out one column per cycle. The sequence stops after the programmed number of beats, or when a stop strobe arrives, or it is replaced at once by a new start.

Two orderings are supported. In sequential order the low bits count upward and wrap inside an aligned block of the burst length, while the upper column bits stay fixed. In interleaved order, beat k uses the start column with its low bits XORed with k. A full-page setting is allowed only in sequential order. It steps through all 256 columns of the row with wrap-around and runs until it is stopped. Bank and row handling, data storage and read latency delay belong to other blocks.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After a synchronous active-high reset, `beat_valid_o`, `last_beat_o` and `cfg_illegal_o` are 0 and `col_o` is 0.
- R2: When `start_i` is sampled high at a clock edge, then after that edge `beat_valid_o` is 1 and `col_o` equals the sampled `start_col_i` (beat 0). Each following cycle presents the next beat.
- R3: Length codes 0, 1, 2 and 3 select burst lengths 1, 2, 4 and 8 (N = 2^code). In sequential order (`interleave_i` = 0), beat k is formed as follows: the low log2(N) bits of the start column are incremented by k modulo N, and the upper bits stay unchanged.
- R4: In interleaved order (`interleave_i` = 1), beat k is the start column with its low log2(N) bits XORed with k.
- R5: Length code 7 with sequential order selects full page. Beat k is the start column plus k modulo 256, so the address wraps from 255 to 0. The burst continues until it is stopped or restarted.
- R6: `last_beat_o` is 1 exactly on beat N-1 of a non-full-page burst, and is never 1 during a full-page burst or while `beat_valid_o` is 0.
- R7: A burst produces exactly N valid beats. In the cycle after the last beat, `beat_valid_o` is 0 unless a new start was sampled.
- R8: When `stop_i` is sampled high and `start_i` is low, `beat_valid_o` is 0 after that edge. While no burst is active, `stop_i` has no effect.
- R9: A start sampled during a burst restarts the sequence with the new column and settings at the next cycle. A start takes priority over a stop sampled in the same cycle.
- R10: Length code 7 with interleaved order, and length codes 4 to 6 in either order, are illegal. Such a start sets `cfg_illegal_o` (latched until the next start) and runs as a burst of length 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for a new burst (also interrupts one in progress) |
| start_col_i | input | 8 | Starting column, sampled with start_i |
| len_code_i | input | 3 | Burst length code: 0..3 give 2^code beats, 7 full page |
| interleave_i | input | 1 | 0 sequential order, 1 interleaved order |
| stop_i | input | 1 | Ends the current burst |
| col_o | output | 8 | Column address of the current beat |
| beat_valid_o | output | 1 | A beat is presented this cycle |
| last_beat_o | output | 1 | Current beat is the final beat of the burst |
| cfg_illegal_o | output | 1 | The settings of the latest start were illegal |

## Verification
The assertions watch several properties every cycle. The upper column bits stay fixed across consecutive sequential beats. A full-page burst steps by one modulo 256. The last-beat flag never appears without a valid beat or in full page. The beat count never passes N-1. Validity drops after a last beat or a stop, and a start always yields beat 0 at its own column. The interleaved XOR pattern, the exact count of beats, and restarts in mid-burst with changed settings are shown by the bench. It compares every cycle against a model built from the requirements, under directed corners and seeded random sequences of starts and stops.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;
  localparam int COL_W_DEF   = 8;
  localparam int LEN_W_DEF   = 3;
  localparam int MAX_LOG_DEF = 3;
  localparam int FULL_CODE_DEF = 7;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
  import sdram_burst_pkg::*;
#(
  parameter int COL_W     = COL_W_DEF,
  parameter int LEN_W     = LEN_W_DEF,
  parameter int MAX_LOG   = MAX_LOG_DEF,
  parameter int FULL_CODE = FULL_CODE_DEF
) (
  input  logic [LEN_W-1:0] len_code,
  input  burst_order_e     order,
  output logic [COL_W-1:0] wrap_mask,
  output logic             full_page,
  output logic             illegal
);
  always_comb begin
    wrap_mask = '0;
    full_page = 1'b0;
    illegal   = 1'b0;
    if (int'(len_code) == FULL_CODE) begin
      if (order == ORD_ILV) begin
        illegal = 1'b1;
      end else begin
        full_page = 1'b1;
        wrap_mask = '1;
      end
    end else if (int'(len_code) <= MAX_LOG) begin
      for (int i = 0; i < COL_W; i++) begin
        wrap_mask[i] = (i < int'(len_code));
      end
    end else begin
      illegal = 1'b1;
    end
  end
endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = COL_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic [COL_W-1:0] mask_in,
  input  logic             full_in,
  input  burst_order_e     order_in,
  output logic [COL_W-1:0] beat_n,
  output logic [COL_W-1:0] mask_n,
  output logic             full_n,
  output burst_order_e     order_n,
  output logic             active_n,
  output logic             last_n
);
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] mask_q;
  logic             full_q;
  burst_order_e     order_q;
  logic             active_q;
  logic             at_end_q;

  assign at_end_q = active_q && !full_q && (beat_q == mask_q);

  always_comb begin
    mask_n   = start ? mask_in  : mask_q;
    full_n   = start ? full_in  : full_q;
    order_n  = start ? order_in : order_q;
    beat_n   = beat_q;
    active_n = active_q;
    if (start) begin
      beat_n   = '0;
      active_n = 1'b1;
    end else if (stop) begin
      active_n = 1'b0;
    end else if (active_q) begin
      if (at_end_q) active_n = 1'b0;
      else          beat_n   = beat_q + 1'b1;
    end
    last_n = active_n && !full_n && (beat_n == mask_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q   <= '0;
      mask_q   <= '0;
      full_q   <= 1'b0;
      order_q  <= ORD_SEQ;
      active_q <= 1'b0;
    end else begin
      beat_q   <= beat_n;
      mask_q   <= mask_n;
      full_q   <= full_n;
      order_q  <= order_n;
      active_q <= active_n;
    end
  end

  // R7: the beat index never passes the final beat of a bounded burst
  a_r7_beat_bounded: assert property (@(posedge clk) disable iff (rst)
    (active_q && !full_q) |-> ((beat_q & ~mask_q) == '0));

  // R7: a reached final beat ends the burst unless restarted
  a_r7_end_stops: assert property (@(posedge clk) disable iff (rst)
    (at_end_q && !start) |=> !active_q);

  // R8: stop without start clears the burst
  a_r8_stop_clears: assert property (@(posedge clk) disable iff (rst)
    (stop && !start) |=> !active_q);

  // R9: a start always restarts at beat zero
  a_r9_start_beat0: assert property (@(posedge clk) disable iff (rst)
    start |=> (active_q && beat_q == '0));
endmodule

// File: rtl/burst_col_map.sv
module burst_col_map
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = COL_W_DEF
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  burst_order_e     order,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] seq_sum;

  assign seq_sum = base + beat;

  always_comb begin
    if (order == ORD_ILV) col = base ^ (beat & mask);
    else                  col = (base & ~mask) | (seq_sum & mask);
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import sdram_burst_pkg::*;
#(
  parameter int COL_W     = COL_W_DEF,
  parameter int LEN_W     = LEN_W_DEF,
  parameter int MAX_LOG   = MAX_LOG_DEF,
  parameter int FULL_CODE = FULL_CODE_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [LEN_W-1:0] len_code_i,
  input  logic             interleave_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             beat_valid_o,
  output logic             last_beat_o,
  output logic             cfg_illegal_o
);
  burst_order_e     order_in;
  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic             dec_illegal;
  logic [COL_W-1:0] beat_n;
  logic [COL_W-1:0] mask_n;
  logic             full_n;
  burst_order_e     order_n;
  logic             active_n;
  logic             last_n;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] base_n;
  logic [COL_W-1:0] col_n;
  logic [COL_W-1:0] mask_o_q;
  logic             full_o_q;

  assign order_in = interleave_i ? ORD_ILV : ORD_SEQ;
  assign base_n   = start_i ? start_col_i : base_q;

  burst_cfg_decode #(
    .COL_W(COL_W), .LEN_W(LEN_W), .MAX_LOG(MAX_LOG), .FULL_CODE(FULL_CODE)
  ) u_dec (
    .len_code (len_code_i),
    .order    (order_in),
    .wrap_mask(dec_mask),
    .full_page(dec_full),
    .illegal  (dec_illegal)
  );

  burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start_i),
    .stop    (stop_i),
    .mask_in (dec_mask),
    .full_in (dec_full),
    .order_in(order_in),
    .beat_n  (beat_n),
    .mask_n  (mask_n),
    .full_n  (full_n),
    .order_n (order_n),
    .active_n(active_n),
    .last_n  (last_n)
  );

  burst_col_map #(.COL_W(COL_W)) u_map (
    .base (base_n),
    .beat (beat_n),
    .mask (mask_n),
    .order(order_n),
    .col  (col_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q        <= '0;
      col_o         <= '0;
      beat_valid_o  <= 1'b0;
      last_beat_o   <= 1'b0;
      cfg_illegal_o <= 1'b0;
      mask_o_q      <= '0;
      full_o_q      <= 1'b0;
    end else begin
      base_q        <= base_n;
      col_o         <= col_n;
      beat_valid_o  <= active_n;
      last_beat_o   <= last_n;
      mask_o_q      <= mask_n;
      full_o_q      <= full_n;
      if (start_i) cfg_illegal_o <= dec_illegal;
    end
  end

  // R2 / R9: a start shows beat zero at its own column next cycle
  a_r9_start_loads: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (beat_valid_o && col_o == $past(start_col_i)));

  // R3: consecutive bounded sequential beats keep the upper column bits
  a_r3_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    (beat_valid_o && $past(beat_valid_o) && !$past(start_i)
     && !full_o_q && order_n == ORD_SEQ && !start_i)
    |-> ((col_o & ~mask_o_q) == ($past(col_o) & ~mask_o_q)));

  // R5: full page steps by one modulo the row size
  a_r5_full_step: assert property (@(posedge clk) disable iff (rst)
    (beat_valid_o && $past(beat_valid_o) && !$past(start_i) && full_o_q)
    |-> (col_o == $past(col_o) + 1'b1));

  // R6: last flag only on a valid beat and never in full page
  a_r6_last_qual: assert property (@(posedge clk) disable iff (rst)
    last_beat_o |-> (beat_valid_o && !full_o_q));

  // R7: after the final beat the output goes idle unless restarted
  a_r7_idle_after_last: assert property (@(posedge clk) disable iff (rst)
    (last_beat_o && !start_i) |=> !beat_valid_o);

  // R8: stop without start ends the burst
  a_r8_stop_idle: assert property (@(posedge clk) disable iff (rst)
    (stop_i && !start_i) |=> !beat_valid_o);
endmodule

// File: tb/tb_sdram_burst_colgen.sv
`timescale 1ns/1ps
module tb_sdram_burst_colgen;
  logic       clk = 1'b0;
  logic       rst;
  logic       start_i;
  logic [7:0] start_col_i;
  logic [2:0] len_code_i;
  logic       interleave_i;
  logic       stop_i;
  logic [7:0] col_o;
  logic       beat_valid_o;
  logic       last_beat_o;
  logic       cfg_illegal_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state
  bit       m_act;
  bit [7:0] m_k;
  bit [7:0] m_base;
  bit [2:0] m_code;
  bit       m_il;
  bit       m_ill;

  always #2.5 clk = ~clk;

  sdram_burst_colgen dut (
    .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .interleave_i(interleave_i), .stop_i(stop_i),
    .col_o(col_o), .beat_valid_o(beat_valid_o), .last_beat_o(last_beat_o),
    .cfg_illegal_o(cfg_illegal_o)
  );

  function automatic bit is_full(bit [2:0] c, bit il);
    return (c == 3'd7) && !il;
  endfunction

  function automatic bit [7:0] wmask(bit [2:0] c, bit il);
    if (is_full(c, il)) return 8'hFF;
    if (c <= 3'd3) return 8'((1 << c) - 1);
    return 8'h00;
  endfunction

  function automatic bit [7:0] exp_col(bit [7:0] b, bit [7:0] k, bit [2:0] c, bit il);
    bit [7:0] m;
    bit [7:0] s;
    m = wmask(c, il);
    s = b + k;
    if (il) return b ^ (k & m);
    return (b & ~m) | (s & m);
  endfunction

  task automatic check(string tag, bit ev, bit [7:0] ec, bit el, bit ei);
    bit ok;
    checks++;
    ok = (beat_valid_o == ev) && (last_beat_o == el) && (cfg_illegal_o == ei)
         && (!ev || col_o == ec);
    if (!ok) begin
      fails++;
      $display("FAIL %s: got valid=%0b col=%02h last=%0b ill=%0b, expected valid=%0b col=%02h last=%0b ill=%0b",
               tag, beat_valid_o, col_o, last_beat_o, cfg_illegal_o, ev, ec, el, ei);
    end
  endtask

  task automatic cyc(bit st, bit [7:0] sc, bit [2:0] lc, bit il, bit sp, string tag);
    bit [7:0] m;
    start_i = st; start_col_i = sc; len_code_i = lc; interleave_i = il; stop_i = sp;
    @(posedge clk);
    if (st) begin
      m_act = 1; m_k = 0; m_base = sc; m_code = lc; m_il = il;
      m_ill = (lc == 3'd7 && il) || (lc > 3'd3 && lc != 3'd7);
    end else if (sp) begin
      m_act = 0;
    end else if (m_act) begin
      m = wmask(m_code, m_il);
      if (!is_full(m_code, m_il) && m_k == m) m_act = 0;
      else m_k = m_k + 1;
    end
    @(negedge clk);
    if (tag == "") begin
      if (is_full(m_code, m_il)) tag = "R5 full page";
      else if (m_il)             tag = "R4 interleaved";
      else                       tag = "R3 sequential";
    end
    check(tag, m_act, exp_col(m_base, m_k, m_code, m_il),
          m_act && !is_full(m_code, m_il) && m_k == wmask(m_code, m_il), m_ill);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, 3'd0, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    start_i = 0; start_col_i = 0; len_code_i = 0; interleave_i = 0; stop_i = 0;
    m_act = 0; m_k = 0; m_base = 0; m_code = 0; m_il = 0; m_ill = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    checks++;
    if (beat_valid_o !== 0 || last_beat_o !== 0 || cfg_illegal_o !== 0 || col_o !== 0) begin
      fails++;
      $display("FAIL R1: got valid=%0b last=%0b ill=%0b col=%02h, expected all 0",
               beat_valid_o, last_beat_o, cfg_illegal_o, col_o);
    end
    // R8 stop while idle has no effect
    cyc(0, 8'h00, 3'd0, 0, 1, "R8 idle stop");
    // R2/R3 sequential BL4 from 2E: 2E 2F 2C 2D
    cyc(1, 8'h2E, 3'd2, 0, 0, "R2 first beat");
    idle(3, "R3 seq wrap");
    idle(1, "R7 idle after last");
    // R4 interleaved BL8 from 35: 35 34 37 36 31 30 33 32
    cyc(1, 8'h35, 3'd3, 1, 0, "R4 ilv first");
    idle(7, "R4 interleaved");
    idle(1, "R7 idle after last");
    // R6 length 1
    cyc(1, 8'h91, 3'd0, 0, 0, "R6 BL1 last");
    idle(1, "R7 BL1 ends");
    // R5 full page wrap FE FF 00 01 ..., then R8 stop
    cyc(1, 8'hFE, 3'd7, 0, 0, "R5 full start");
    idle(6, "R5 full wrap");
    cyc(0, 8'h00, 3'd0, 0, 1, "R8 stop full page");
    // R9 interrupt mid-burst and start beats stop
    cyc(1, 8'h40, 3'd3, 0, 0, "R9 first burst");
    idle(2, "R9 first burst");
    cyc(1, 8'h13, 3'd1, 1, 0, "R9 interrupt");
    cyc(1, 8'h77, 3'd2, 0, 1, "R9 start over stop");
    idle(4, "R9 after restart");
    // R10 illegal settings
    cyc(1, 8'h5A, 3'd7, 1, 0, "R10 full+ilv");
    idle(1, "R10 runs as BL1");
    cyc(1, 8'h22, 3'd5, 0, 0, "R10 reserved code");
    idle(1, "R10 runs as BL1");
    cyc(1, 8'h22, 3'd1, 0, 0, "R10 flag cleared");
    idle(2, "R10 legal again");
    // seeded random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      bit st;
      bit sp;
      bit [2:0] lc;
      st = ($urandom % 8) == 0;
      sp = ($urandom % 24) == 0;
      case ($urandom % 6)
        0: lc = 3'd0;
        1: lc = 3'd1;
        2: lc = 3'd2;
        3: lc = 3'd3;
        4: lc = 3'd7;
        default: lc = 3'($urandom);
      endcase
      cyc(st, 8'($urandom), lc, 1'($urandom), sp, "");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule